// File: doc/BRIEF.md
# Profiling Arm and Alignment Controller

This controller decides, cycle by cycle, whether profiling capture into the trace store is allowed. It combines a profiling-enable configuration bit, an output-pin enable bit and a two-bit alignment selector with the debug arm request, the final-state indication from the trigger sequencer, a disarm event, a trace store overflow and the serial transmitter's busy flag.

End alignment starts capture in the cycle after arming. Begin alignment holds capture off until the sequencer reports its final state. The mid alignment code quietly behaves as end alignment. Once started, capture runs without any line limit until an overflow or a disarm, and it drops in the very cycle either event is seen. After a disarm, the transmitter may still be draining stored data. During that time, register writes are blocked and reads of trace data return a fixed marker code. While profiling is armed, the external capture gate is forced open.

Top module: `prof_arm_ctrl`

## Requirements
- R1: After reset, cap_en is 0, wr_block is 0 and rd_data follows trc_rd_data (the block is disarmed and the transmitter is idle).
- R2: Alignment code 2'b00 (end) and the spare code 2'b11 (also end): when arm_req is pulsed with cfg_prof_en=1, cap_en goes to 1 in the next cycle.
- R3: Alignment code 2'b01 (mid) behaves exactly as end alignment: cap_en is 1 in the cycle after the arm pulse.
- R4: Alignment code 2'b10 (begin): cap_en stays 0 while the block is armed until seq_final is seen, then goes to 1 in the next cycle.
- R5: Once started, cap_en stays 1 for any number of cycles while no overflow, disarm or profile-disable occurs.
- R6: buf_ovf forces cap_en to 0 in the same cycle, and cap_en stays 0 until a disarm followed by a new arm.
- R7: disarm forces cap_en to 0 in the same cycle and clears the armed state, so cap_en stays 0 afterwards.
- R8: With cfg_prof_en=0, cap_en is 0 in every cycle, even when armed.
- R9: pins_en is 1 only when both cfg_pin_en and cfg_prof_en are 1.
- R10: While cfg_prof_en is 1 and the block is armed, gate_pass is 1 whatever ext_gate is; otherwise gate_pass equals ext_gate.
- R11: wr_block is 1 exactly when the block is disarmed and tx_active is 1.
- R12: While disarmed with tx_active=1, rd_data is 8'hEE; otherwise rd_data equals trc_rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_prof_en | input | 1 | Profiling enable configuration bit |
| cfg_pin_en | input | 1 | Profiling output-pin enable bit |
| cfg_align | input | 2 | Alignment selector: 00 end, 01 mid, 10 begin, 11 end |
| arm_req | input | 1 | One-cycle arm request |
| seq_final | input | 1 | Sequencer has reached its final state |
| disarm | input | 1 | One-cycle disarm event (sequencer returned to idle) |
| buf_ovf | input | 1 | Trace store overflow |
| tx_active | input | 1 | Serial transmitter still draining |
| ext_gate | input | 1 | External capture gate |
| trc_rd_data | input | 8 | Trace data read value from the store |
| cap_en | output | 1 | Profiling capture enable |
| pins_en | output | 1 | Route serial data and clock pins to profiling |
| gate_pass | output | 1 | Effective capture gate |
| wr_block | output | 1 | Suppress register writes |
| rd_data | output | 8 | Trace data read value after override |

## Verification
The hardest situation to reach is the drain window after a disarm, where the arm flag is already clear but the transmitter still reports activity. In that window the write block and the marker code must appear, and they must vanish as soon as either condition ends. The bench drives tx_active high across an armed-to-disarmed transition, so the override is seen both absent and present with the same read data. The begin-aligned path is also hard to reach. The bench holds the arm active for many cycles without a final-state indication, then after the final-state pulse holds capture for over a hundred cycles. This shows that there is no hidden line limit.

// File: rtl/prof_arm_pkg.sv
package prof_arm_pkg;
   typedef enum logic [1:0] {
      ALN_END   = 2'b00,
      ALN_MID   = 2'b01,
      ALN_BEGIN = 2'b10,
      ALN_SPARE = 2'b11
   } align_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_CAPT = 2'd2,
      ST_HALT = 2'd3
   } cap_st_e;
endpackage

// File: rtl/prof_align_decode.sv
module prof_align_decode
   import prof_arm_pkg::*;
#(
   parameter int ALIGN_W    = 2,
   parameter bit MID_AS_END = 1'b1
) (
   input  logic [ALIGN_W-1:0] align_raw,
   output logic               wait_final
);
   generate
      if (ALIGN_W != 2) begin : g_bad_w
         $error("prof_align_decode: ALIGN_W must be 2");
      end
   endgenerate

   align_e mode;
   assign mode = align_e'(align_raw);

   generate
      if (MID_AS_END) begin : g_mid_end
         always_comb begin
            wait_final = (mode == ALN_BEGIN);
         end
      end else begin : g_mid_begin
         always_comb begin
            wait_final = (mode == ALN_BEGIN) || (mode == ALN_MID);
         end
      end
   endgenerate

   // R3: mid code falls back to end alignment
   always_comb begin
      if (MID_AS_END && mode == ALN_MID) begin
         p_mid_fallback_r3: assert (!wait_final);
      end
   end
endmodule

// File: rtl/prof_arm_track.sv
module prof_arm_track (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_req,
   input  logic disarm,
   output logic armed_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (disarm) begin
         armed_q <= 1'b0;
      end else if (arm_req) begin
         armed_q <= 1'b1;
      end
   end

   p_disarm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      disarm |=> !armed_q);
endmodule

// File: rtl/prof_cap_fsm.sv
module prof_cap_fsm
   import prof_arm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic prof_en,
   input  logic wait_final,
   input  logic arm_req,
   input  logic armed_q,
   input  logic seq_final,
   input  logic disarm,
   input  logic buf_ovf,
   output logic cap_en
);
   cap_st_e st_q, st_d;
   logic    start;

   assign start = prof_en && (arm_req || armed_q);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (start && !disarm && !buf_ovf) begin
               st_d = wait_final ? ST_WAIT : ST_CAPT;
            end
         end
         ST_WAIT: begin
            if (disarm || !prof_en) begin
               st_d = ST_IDLE;
            end else if (seq_final) begin
               st_d = ST_CAPT;
            end
         end
         ST_CAPT: begin
            if (disarm || !prof_en) begin
               st_d = ST_IDLE;
            end else if (buf_ovf) begin
               st_d = ST_HALT;
            end
         end
         ST_HALT: begin
            if (disarm) begin
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   assign cap_en = (st_q == ST_CAPT) && prof_en && !buf_ovf && !disarm;

   p_ovf_cuts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      buf_ovf |-> !cap_en);
   p_ovf_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_ovf && !disarm && !arm_req && (st_q == ST_CAPT)) |=> !cap_en);
   p_disarm_cuts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      disarm |=> !cap_en);
   p_noprof_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !prof_en |-> !cap_en);
   p_start_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_en) |-> armed_q);
   p_begin_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_WAIT) && !seq_final) |=> !cap_en);
endmodule

// File: rtl/prof_drain_guard.sv
module prof_drain_guard #(
   parameter int              CODE_W   = 8,
   parameter logic [CODE_W-1:0] OVR_CODE = 8'hEE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed_q,
   input  logic              tx_active,
   input  logic [CODE_W-1:0] rd_in,
   output logic              wr_block,
   output logic [CODE_W-1:0] rd_out
);
   generate
      if (CODE_W < 1) begin : g_bad_w
         $error("prof_drain_guard: CODE_W must be positive");
      end
   endgenerate

   logic draining;
   assign draining = !armed_q && tx_active;
   assign wr_block = draining;
   assign rd_out   = draining ? OVR_CODE : rd_in;

   p_armed_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (rd_out == rd_in));
   p_idle_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active |-> !wr_block);
endmodule

// File: rtl/prof_arm_ctrl.sv
module prof_arm_ctrl
   import prof_arm_pkg::*;
#(
   parameter int                ALIGN_W    = 2,
   parameter int                CODE_W     = 8,
   parameter logic [CODE_W-1:0] OVR_CODE   = 8'hEE,
   parameter bit                MID_AS_END = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_prof_en,
   input  logic              cfg_pin_en,
   input  logic [ALIGN_W-1:0] cfg_align,
   input  logic              arm_req,
   input  logic              seq_final,
   input  logic              disarm,
   input  logic              buf_ovf,
   input  logic              tx_active,
   input  logic              ext_gate,
   input  logic [CODE_W-1:0] trc_rd_data,
   output logic              cap_en,
   output logic              pins_en,
   output logic              gate_pass,
   output logic              wr_block,
   output logic [CODE_W-1:0] rd_data
);
   logic wait_final;
   logic armed_q;

   prof_align_decode #(.ALIGN_W(ALIGN_W), .MID_AS_END(MID_AS_END)) u_dec (
      .align_raw (cfg_align),
      .wait_final(wait_final)
   );

   prof_arm_track u_arm (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_req(arm_req),
      .disarm (disarm),
      .armed_q(armed_q)
   );

   prof_cap_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .prof_en   (cfg_prof_en),
      .wait_final(wait_final),
      .arm_req   (arm_req),
      .armed_q   (armed_q),
      .seq_final (seq_final),
      .disarm    (disarm),
      .buf_ovf   (buf_ovf),
      .cap_en    (cap_en)
   );

   prof_drain_guard #(.CODE_W(CODE_W), .OVR_CODE(OVR_CODE)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed_q  (armed_q),
      .tx_active(tx_active),
      .rd_in    (trc_rd_data),
      .wr_block (wr_block),
      .rd_out   (rd_data)
   );

   assign pins_en   = cfg_pin_en && cfg_prof_en;
   assign gate_pass = (cfg_prof_en && armed_q) ? 1'b1 : ext_gate;

   p_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pins_en |-> (cfg_prof_en && cfg_pin_en));
   p_gate_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_prof_en && armed_q) |-> gate_pass);
   p_drain_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_block |-> (rd_data == OVR_CODE));
endmodule

// File: tb/prof_arm_ctrl_bench.sv
module prof_arm_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_prof_en = 0, cfg_pin_en = 0, arm_req = 0, seq_final = 0;
   logic       disarm = 0, buf_ovf = 0, tx_active = 0, ext_gate = 0;
   logic [1:0] cfg_align = 2'b00;
   logic [7:0] trc_rd_data = 8'h00;
   logic       cap_en, pins_en, gate_pass, wr_block;
   logic [7:0] rd_data;

   // next-cycle input values, applied by the driver
   logic       n_prof = 0, n_pin = 0, n_arm = 0, n_fin = 0;
   logic       n_dis = 0, n_ovf = 0, n_tx = 0, n_gate = 0;
   logic [1:0] n_align = 2'b00;
   logic [7:0] n_rdd = 8'h00;

   typedef struct {
      logic       cap;
      logic       pins;
      logic       gate;
      logic       wrb;
      logic [7:0] rd;
      string      tag;
   } exp_t;
   exp_t q[$];

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   prof_arm_ctrl u_prof_arm_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_prof_en(cfg_prof_en), .cfg_pin_en(cfg_pin_en),
      .cfg_align(cfg_align), .arm_req(arm_req), .seq_final(seq_final),
      .disarm(disarm), .buf_ovf(buf_ovf), .tx_active(tx_active),
      .ext_gate(ext_gate), .trc_rd_data(trc_rd_data), .cap_en(cap_en),
      .pins_en(pins_en), .gate_pass(gate_pass), .wr_block(wr_block), .rd_data(rd_data)
   );

   task automatic step(input logic c, input logic p, input logic g, input logic w,
                       input logic [7:0] r, input string tag);
      exp_t e;
      @(negedge clk);
      cfg_prof_en = n_prof; cfg_pin_en = n_pin; cfg_align = n_align;
      arm_req = n_arm; seq_final = n_fin; disarm = n_dis; buf_ovf = n_ovf;
      tx_active = n_tx; ext_gate = n_gate; trc_rd_data = n_rdd;
      e.cap = c; e.pins = p; e.gate = g; e.wrb = w; e.rd = r; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compare outputs against queued expectations
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (cap_en !== e.cap || pins_en !== e.pins || gate_pass !== e.gate ||
                wr_block !== e.wrb || rd_data !== e.rd) begin
               errors++;
               $display("FAIL %s: got cap=%b pins=%b gate=%b wrb=%b rd=%h exp cap=%b pins=%b gate=%b wrb=%b rd=%h",
                        e.tag, cap_en, pins_en, gate_pass, wr_block, rd_data,
                        e.cap, e.pins, e.gate, e.wrb, e.rd);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      n_rdd = 8'h5A;
      step(0, 0, 0, 0, 8'h5A, "R1 reset");
      // R9 pins need both bits
      n_pin = 1;
      step(0, 0, 0, 0, 8'h5A, "R9 pin without prof");
      n_prof = 1;
      step(0, 1, 0, 0, 8'h5A, "R9 pin and prof");
      // R2 end alignment
      n_align = 2'b00; n_arm = 1;
      step(0, 1, 0, 0, 8'h5A, "R2 arm cycle");
      n_arm = 0;
      step(1, 1, 1, 0, 8'h5A, "R2 end start / R10 gate forced");
      n_tx = 1; n_rdd = 8'h33;
      step(1, 1, 1, 0, 8'h33, "R11 R12 armed no override");
      n_dis = 1;
      step(0, 1, 1, 0, 8'h33, "R7 disarm same cycle");
      n_dis = 0;
      step(0, 1, 0, 1, 8'hEE, "R11 R12 drain override");
      step(0, 1, 0, 1, 8'hEE, "R7 stays off while draining");
      n_tx = 0;
      step(0, 1, 0, 0, 8'h33, "R11 R12 drain over");
      // R3 mid falls back to end
      n_align = 2'b01; n_arm = 1;
      step(0, 1, 0, 0, 8'h33, "R3 arm cycle");
      n_arm = 0;
      step(1, 1, 1, 0, 8'h33, "R3 mid starts like end");
      // R6 overflow
      n_ovf = 1;
      step(0, 1, 1, 0, 8'h33, "R6 overflow same cycle");
      n_ovf = 0;
      for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 8'h33, "R6 held after overflow");
      n_dis = 1;
      step(0, 1, 1, 0, 8'h33, "R6 disarm after overflow");
      n_dis = 0;
      // R2 spare code 11
      n_align = 2'b11; n_arm = 1;
      step(0, 1, 0, 0, 8'h33, "R2 spare arm");
      n_arm = 0;
      step(1, 1, 1, 0, 8'h33, "R2 spare code as end");
      n_dis = 1;
      step(0, 1, 1, 0, 8'h33, "R7 disarm");
      n_dis = 0;
      // R4 begin alignment
      n_align = 2'b10; n_arm = 1;
      step(0, 1, 0, 0, 8'h33, "R4 arm cycle");
      n_arm = 0;
      for (int i = 0; i < 10; i++) step(0, 1, 1, 0, 8'h33, "R4 waits for final");
      n_fin = 1;
      step(0, 1, 1, 0, 8'h33, "R4 final cycle");
      n_fin = 0;
      step(1, 1, 1, 0, 8'h33, "R4 starts after final");
      // R5 no line limit
      for (int i = 0; i < 120; i++) step(1, 1, 1, 0, 8'h33, "R5 long capture");
      n_pin = 0;
      step(1, 0, 1, 0, 8'h33, "R9 pin off");
      // R8 profile disable
      n_prof = 0;
      step(0, 0, 0, 0, 8'h33, "R8 prof off while capturing");
      step(0, 0, 0, 0, 8'h33, "R8 stays off");
      n_gate = 1;
      step(0, 0, 1, 0, 8'h33, "R10 gate follows ext when not profiling");
      n_dis = 1; n_gate = 0;
      step(0, 0, 0, 0, 8'h33, "R7 disarm");
      n_dis = 0; n_arm = 1; n_align = 2'b00;
      step(0, 0, 0, 0, 8'h33, "R8 arm without prof");
      n_arm = 0;
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 8'h33, "R8 no capture without prof");
      n_gate = 1;
      step(0, 0, 1, 0, 8'h33, "R10 armed but prof off follows ext");
      wait (q.size() == 0);
      @(negedge clk);
      #4;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule